// File: doc/BRIEF.md
# Effective Address Generator

This unit turns the address fields of a 32-bit instruction word into the final address of a memory operand. The 17-bit reference address in the low bits of the instruction can be replaced once by a word read from memory (indirection), then offset by an index register, and in virtual mode translated from a 256-entry page space into a 20-bit real address. Instructions held in trap or interrupt locations may carry a 20-bit reference address instead. That form may still go through indirection, but it is never indexed and never translated.

A request is started with a one-cycle `start` pulse. The unit then walks through its stages and raises `busy` until a one-cycle `done` strobe marks `real_addr` and `reg_sel` as valid. Both outputs hold their value until the next request completes. The memory read uses a request/ready handshake. The index-register and page-map ports are combinational lookups that the surrounding logic answers in the same cycle. When the effective address falls in 0 to 15, `reg_sel` tells the consumer to use the current register block instead of main memory.

Top module: `ea_gen`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `reg_sel` are low and `real_addr` is zero.
- R2: With `insn[31]`=0 and X field `insn[19:17]`=0 (not the trap form), the effective address is `insn[16:0]` zero-extended to 20 bits. In real and real-extended modes (`mode` 0 and 1; value 3 acts as 0), that value is the output.
- R3: When `insn[31]`=1, exactly one memory read is made at the reference address. `mem_req` stays high with `mem_addr` stable until `mem_rdy`. In real and virtual modes, bits [16:0] of the returned word replace the reference address. Indirection never chains.
- R4: In real-extended mode (`mode`=1), an indirect read takes bits [19:0] of the returned word as the new 20-bit reference address.
- R5: A nonzero X field selects the register given by `idx_sel`=X. Its value is added after any indirection, modulo 2^17 in real and virtual modes.
- R6: In real-extended mode, the indexed sum is taken modulo 2^20.
- R7: When `trap_loc`=1 and `insn[21]`=0, the reference address is `insn[19:0]`, and indirection yields bits [19:0] of the fetched word. No indexing or mapping is applied, in any mode.
- R8: In virtual mode (`mode`=2), outside the trap form, `map_page` carries effective address bits [16:9], and the output is {`map_real`, effective address bits [8:0]}.
- R9: `reg_sel` is 1 exactly when the effective address before mapping is below 16.
- R10: `done` is high for exactly one cycle per request, and `busy` is high from the cycle after `start` until `done`. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one address computation |
| insn | input | 32 | Instruction word |
| mode | input | 2 | 0 real, 1 real-extended, 2 virtual, 3 as real |
| trap_loc | input | 1 | Instruction comes from a trap or interrupt location |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 20 | Indirect word address |
| mem_rdy | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Fetched word |
| idx_sel | output | 3 | Index register number |
| idx_val | input | 32 | Contents of the selected index register |
| map_page | output | 8 | Virtual page number to translate |
| map_real | input | 11 | Real page for `map_page` |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| real_addr | output | 20 | Final real address |
| reg_sel | output | 1 | Address refers to the register block |

## Verification
On every cycle, the assertions check the handshake and sequencing rules. These are that the read request holds a steady address until it is accepted and never re-issues after acceptance, that requests occur only while busy, and that the completion strobe is a single cycle followed by idle. The address arithmetic can only be shown by the bench's sweeps. The sweeps cover every mode, trap-form choice, indirection and X value against a computed model. They show the one-level limit, the order of indirection and indexing, the modulus of the sum, the bypass of mapping, and the register-block flag.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int INSN_W    = 32;
    localparam int REF_W     = 17;
    localparam int EXT_W     = 20;
    localparam int OFS_W     = 9;
    localparam int PAGE_W    = REF_W - OFS_W;
    localparam int RPG_W     = EXT_W - OFS_W;
    localparam int XW        = 3;
    localparam int REG_LIMIT = 16;
    localparam int PAD_W     = EXT_W - REF_W;

    typedef enum logic [2:0] {S_IDLE, S_IND, S_IDX, S_MAP, S_DONE} st_e;
    typedef enum logic [1:0] {M_REAL = 2'd0, M_REXT = 2'd1, M_VIRT = 2'd2, M_RSV = 2'd3} mode_e;

    typedef struct packed {
        st_e              st;
        mode_e            mode;
        logic             t20;
        logic [XW-1:0]    xs;
        logic [EXT_W-1:0] ea;
        logic [EXT_W-1:0] out;
        logic             rsel;
    } regs_t;

    // Stage that follows the (optional) indirect fetch
    function automatic st_e after_ind(logic [XW-1:0] xs, logic t20, mode_e m);
        if (xs != '0)
            return S_IDX;
        else if (m == M_VIRT && !t20)
            return S_MAP;
        else
            return S_DONE;
    endfunction
endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              trap_loc,
    output logic              ind,
    output logic              t20,
    output logic [XW-1:0]     xs,
    output logic [EXT_W-1:0]  ref_ea
);
    logic [9:0] insn_unused;
    assign insn_unused = {insn[30:22], insn[20]};

    always_comb begin
        ind    = insn[31];
        t20    = trap_loc & ~insn[21];
        xs     = t20 ? '0 : insn[REF_W+XW-1:REF_W];
        ref_ea = t20 ? insn[EXT_W-1:0] : {{PAD_W{1'b0}}, insn[REF_W-1:0]};
    end
endmodule

// File: rtl/eag_index.sv
module eag_index
    import eag_pkg::*;
(
    input  logic [EXT_W-1:0] ea,
    input  logic [EXT_W-1:0] offset,
    input  logic             wide,
    output logic [EXT_W-1:0] sum
);
    logic [EXT_W-1:0] raw;
    always_comb begin
        raw = ea + offset;
        sum = wide ? raw : {{PAD_W{1'b0}}, raw[REF_W-1:0]};
    end
endmodule

// File: rtl/eag_mapper.sv
module eag_mapper
    import eag_pkg::*;
(
    input  logic [EXT_W-1:0]  ea,
    input  logic [RPG_W-1:0]  rpage,
    output logic [PAGE_W-1:0] vpage,
    output logic [EXT_W-1:0]  mapped
);
    always_comb begin
        vpage  = ea[REF_W-1:OFS_W];
        mapped = {rpage, ea[OFS_W-1:0]};
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [INSN_W-1:0] insn,
    input  logic [1:0]        mode,
    input  logic              trap_loc,
    output logic              mem_req,
    output logic [EXT_W-1:0]  mem_addr,
    input  logic              mem_rdy,
    input  logic [31:0]       mem_rdata,
    output logic [XW-1:0]     idx_sel,
    input  logic [31:0]       idx_val,
    output logic [PAGE_W-1:0] map_page,
    input  logic [RPG_W-1:0]  map_real,
    output logic              busy,
    output logic              done,
    output logic [EXT_W-1:0]  real_addr,
    output logic              reg_sel
);
    regs_t q, d;

    logic             dec_ind, dec_t20;
    logic [XW-1:0]    dec_xs;
    logic [EXT_W-1:0] dec_ea, idx_sum, mapped;
    logic [11:0]      rdata_unused;
    logic [11:0]      idx_unused;

    assign rdata_unused = mem_rdata[31:EXT_W];
    assign idx_unused   = idx_val[31:EXT_W];

    eag_decode u_dec (
        .insn     (insn),
        .trap_loc (trap_loc),
        .ind      (dec_ind),
        .t20      (dec_t20),
        .xs       (dec_xs),
        .ref_ea   (dec_ea)
    );

    eag_index u_idx (
        .ea     (q.ea),
        .offset (idx_val[EXT_W-1:0]),
        .wide   (q.mode == M_REXT),
        .sum    (idx_sum)
    );

    eag_mapper u_map (
        .ea     (q.ea),
        .rpage  (map_real),
        .vpage  (map_page),
        .mapped (mapped)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: if (start) begin
                d.mode = mode_e'(mode);
                d.t20  = dec_t20;
                d.xs   = dec_xs;
                d.ea   = dec_ea;
                d.st   = dec_ind ? S_IND : after_ind(dec_xs, dec_t20, mode_e'(mode));
            end
            S_IND: if (mem_rdy) begin
                // single level: the fetched word is used as-is, never re-fetched
                d.ea = (q.t20 || q.mode == M_REXT) ? mem_rdata[EXT_W-1:0]
                                                   : {{PAD_W{1'b0}}, mem_rdata[REF_W-1:0]};
                d.st = after_ind(q.xs, q.t20, q.mode);
            end
            S_IDX: begin
                d.ea = idx_sum;
                d.st = (q.mode == M_VIRT && !q.t20) ? S_MAP : S_DONE;
            end
            S_MAP:   d.st = S_DONE;
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
        if (d.st == S_DONE && q.st != S_DONE) begin
            d.out  = (q.st == S_MAP) ? mapped : d.ea;
            d.rsel = d.ea < EXT_W'(REG_LIMIT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '{st: S_IDLE, mode: M_REAL, default: '0};
        else
            q <= d;
    end

    assign mem_req   = (q.st == S_IND);
    assign mem_addr  = q.ea;
    assign idx_sel   = q.xs;
    assign busy      = (q.st != S_IDLE);
    assign done      = (q.st == S_DONE);
    assign real_addr = q.out;
    assign reg_sel   = q.rsel;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import eag_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_rdy,
    input logic [EXT_W-1:0] mem_addr,
    input logic             busy,
    input logic             done
);
    // R3: request held with a steady address until accepted
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr));

    // R3: after acceptance no second fetch follows
    a_r3_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rdy |=> !mem_req);

    // R10: reads only happen inside a busy request
    a_r10_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R10: completion strobe lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: unit is idle right after completion
    a_r10_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10: done only while busy
    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind ea_gen ea_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_rdy  (mem_rdy),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (done)
);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [1:0]  mode = '0;
    logic        trap_loc = 1'b0;
    logic        mem_req, mem_rdy = 1'b0;
    logic [19:0] mem_addr;
    logic [31:0] mem_rdata, idx_val;
    logic [2:0]  idx_sel;
    logic [7:0]  map_page;
    logic [10:0] map_real;
    logic        busy, done, reg_sel;
    logic [19:0] real_addr;

    int checks = 0, fails = 0;
    int lat_cfg = 0, wcnt = 0, fetch_total = 0;

    always #2.5 clk = ~clk;

    ea_gen uut (.*);

    function automatic logic [31:0] memf(logic [19:0] a);
        if (a == 20'h3) return 32'h0000_000A;
        return ({12'h0, a} * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction
    function automatic logic [31:0] idxf(logic [2:0] s);
        return ({29'h0, s} * 32'h0002_3457) ^ {s, 29'h0};
    endfunction
    function automatic logic [10:0] mapf(logic [7:0] p);
        return {p[2:0], p} ^ 11'h2A5;
    endfunction

    assign mem_rdata = memf(mem_addr);
    assign idx_val   = idxf(idx_sel);
    assign map_real  = mapf(map_page);

    always @(posedge clk) begin
        if (mem_req && mem_rdy) fetch_total <= fetch_total + 1;
        if (mem_req && !mem_rdy) begin
            if (wcnt >= lat_cfg) mem_rdy <= 1'b1;
            else wcnt <= wcnt + 1;
        end else begin
            mem_rdy <= 1'b0;
            wcnt    <= 0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model of the requirements
    task automatic model(input logic [31:0] w, input logic [1:0] m, input logic tr,
                         output logic [19:0] out, output logic rs, output string tag);
        logic t20 = tr & ~w[21];
        logic [19:0] ea = t20 ? w[19:0] : {3'b0, w[16:0]};
        logic [2:0]  x  = t20 ? 3'd0 : w[19:17];
        logic [31:0] fw;
        logic [19:0] s;
        if (w[31]) begin
            fw = memf(ea);
            ea = (t20 || m == 2'd1) ? fw[19:0] : {3'b0, fw[16:0]};
        end
        if (x != 0) begin
            s  = ea + idxf(x)[19:0];
            ea = (m == 2'd1) ? s : {3'b0, s[16:0]};
        end
        rs  = ea < 20'd16;
        out = (m == 2'd2 && !t20) ? {mapf(ea[16:9]), ea[8:0]} : ea;
        if (t20) tag = "R7";
        else if (m == 2'd2) tag = "R8";
        else if (x != 0) tag = (m == 2'd1) ? "R6" : "R5";
        else if (w[31]) tag = (m == 2'd1) ? "R4" : "R3";
        else tag = "R2";
    endtask

    task automatic run_op(logic [31:0] w, logic [1:0] m, logic tr, int lat, bit poke);
        logic [19:0] eo;
        logic er;
        string tg;
        int n = 0;
        int f0;
        model(w, m, tr, eo, er, tg);
        @(negedge clk);
        insn = w; mode = m; trap_loc = tr; lat_cfg = lat; start = 1'b1;
        f0 = fetch_total;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            chk("R10 busy after start", {31'h0, busy}, 32'h1);
            insn = ~w; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        while (!done && n < 40) begin @(negedge clk); n++; end
        chk({tg, " address"}, {12'h0, real_addr}, {12'h0, eo});
        chk("R9 reg_sel", {31'h0, reg_sel}, {31'h0, er});
        chk("R3 fetch count", fetch_total - f0, w[31] ? 1 : 0);
        @(negedge clk);
        chk("R10 done one cycle", {30'h0, done, busy}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [16:0] refs [4];
        refs[0] = 17'h00003; refs[1] = 17'h1FFFF; refs[2] = 17'h0ABCD; refs[3] = 17'h10200;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {9'h0, busy, done, mem_req, reg_sel, real_addr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {29'h0, busy, done, mem_req}, 32'h0);

        for (int m = 0; m < 4; m++)
            for (int tr = 0; tr < 2; tr++)
                for (int b21 = 0; b21 < 2; b21++)
                    for (int ind = 0; ind < 2; ind++)
                        for (int x = 0; x < 8; x++)
                            for (int r = 0; r < 4; r++)
                                run_op({ind[0], 9'h0A5, b21[0], refs[r][0], x[2:0], refs[r]},
                                       m[1:0], tr[0], (x + r) % 4, 1'b0);

        // R10: start while busy is ignored (long indirect wait)
        run_op({1'b1, 9'h0, 1'b0, 1'b0, 3'd5, 17'h0ABCD}, 2'd2, 1'b0, 3, 1'b1);
        run_op({1'b0, 9'h0, 1'b1, 1'b0, 3'd0, 17'h00007}, 2'd0, 1'b0, 0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 no second result", {30'h0, done, busy}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule